// File: doc/BRIEF.md
# Shared Energy Budget Boost Arbiter

This block splits one package power budget between a cluster of CPU cores and a GPU. Every cycle it receives an unsigned power estimate for each core and one for the GPU, all in the same fixed-point unit. It adds them up and subtracts the total from a programmable package limit. The result goes into a signed energy accumulator, so quiet stretches bank margin that busy stretches can later spend. While the banked margin stays positive, cores may run at their single boost frequency even when the instantaneous total is above the package limit.

The two domains can also lend each other power. When one domain's estimate falls to or below an idle level, the other domain may take a fixed borrow quantum on top of its own domain limit. Only one domain holds the quantum in any cycle, and the GPU wins when both could take it. Each core gets base or boost on its own, based on its request, the deficit lockout, and whether the CPU domain fits inside its effective limit. When the accumulator would go below zero, every core drops to base. Boost returns only after the banked margin climbs above a programmable re-arm level.

Top module: `pwr_budget_arbiter`

## Requirements
- R1: On each clock edge the margin becomes previous margin + package limit − (sum of all core estimates + GPU estimate).
- R2: The margin never exceeds the programmable bank maximum; a larger result is stored as the bank maximum.
- R3: A result below zero is stored as zero and sets the lockout output; on that same edge every core boost grant goes to 0.
- R4: Once set, lockout stays set until an update leaves the margin strictly above the re-arm level; during lockout no core is granted boost.
- R5: Boost is granted while the total estimate exceeds the package limit, as long as the margin does not go below zero.
- R6: When the CPU domain sum is at or below the idle level and the GPU requests a borrow, the GPU credit output is 1 and the GPU effective limit is the GPU domain limit plus the quantum.
- R7: When the GPU estimate is at or below the idle level, at least one core requests boost, and the GPU is not taking the credit, the CPU credit output is 1 and the CPU effective limit is the CPU domain limit plus the quantum.
- R8: The two credit outputs are never both 1; when both domains qualify, the GPU receives the credit.
- R9: Core i (bit i of the request and grant vectors) is granted boost only if it requests boost, independently of the other cores.
- R10: No core is granted boost when the CPU domain sum exceeds the CPU effective limit.
- R11: While reset is high, the margin, lockout, grants, credits and effective limits are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| core_pwr | input | NUM_CORES*PWR_W | Per-core power estimates; core i in bits [i*PWR_W +: PWR_W] |
| gpu_pwr | input | PWR_W | GPU power estimate |
| core_boost_req | input | NUM_CORES | Per-core boost request |
| gpu_borrow_req | input | 1 | GPU asks to borrow the quantum |
| pkg_limit | input | SUM_W | Package power limit per cycle |
| cpu_dom_limit | input | SUM_W | CPU domain limit |
| gpu_dom_limit | input | SUM_W | GPU domain limit |
| borrow_quantum | input | SUM_W | Fixed credit moved to a borrower |
| idle_level | input | SUM_W | A domain at or below this estimate counts as idle |
| bank_max | input | ACC_W | Upper saturation of the margin |
| rearm_level | input | ACC_W | Margin that must be exceeded to leave lockout |
| boost_gnt | output | NUM_CORES | Per-core boost grant (1 = boost, 0 = base) |
| gpu_credit | output | 1 | GPU holds the borrowed quantum |
| cpu_credit | output | 1 | CPU holds the borrowed quantum |
| cpu_limit_eff | output | SUM_W+1 | Current CPU effective limit |
| gpu_limit_eff | output | SUM_W+1 | Current GPU effective limit |
| margin | output | ACC_W | Banked energy margin |
| lockout | output | 1 | Deficit lockout active |

## Verification
The bench uses the default parameters: four cores, 12-bit estimates (SUM_W = 15) and a 20-bit accumulator. The bank maximum and re-arm level are run-time inputs set to a few hundred units, so the upper saturation, the drop to zero and the hysteresis release each happen within a handful of cycles, with exact margin values at every step. Because the core count is four, the bench can mix requests per bit, make the CPU domain sum cross the idle level, and move it above and below the domain limit with and without the borrowed quantum.

// File: rtl/pwr_budget_pkg.sv
package pwr_budget_pkg;

    localparam int unsigned PB_NUM_CORES = 4;
    localparam int unsigned PB_PWR_W     = 12;
    localparam int unsigned PB_ACC_W     = 20;

    // Width that holds the sum of n values of w bits each
    function automatic int unsigned pb_sum_w(input int unsigned n, input int unsigned w);
        return w + $clog2(n + 1);
    endfunction

    // Direction of the borrowed quantum in one cycle
    typedef enum logic [1:0] {
        CR_NONE   = 2'd0,
        CR_TO_GPU = 2'd1,
        CR_TO_CPU = 2'd2
    } credit_dir_e;

    typedef struct packed {
        logic gpu;
        logic cpu;
    } credit_flags_t;

    function automatic credit_flags_t pb_decode_dir(input credit_dir_e d);
        credit_flags_t f;
        f.gpu = (d == CR_TO_GPU);
        f.cpu = (d == CR_TO_CPU);
        return f;
    endfunction

endpackage

// File: rtl/pb_power_sum.sv
module pb_power_sum
    import pwr_budget_pkg::*;
#(
    parameter int unsigned NUM_CORES = PB_NUM_CORES,
    parameter int unsigned PWR_W     = PB_PWR_W,
    parameter int unsigned SUM_W     = pb_sum_w(NUM_CORES, PWR_W)
) (
    input  logic [NUM_CORES*PWR_W-1:0] core_pwr,
    input  logic [PWR_W-1:0]           gpu_pwr,
    output logic [SUM_W-1:0]           cpu_sum,
    output logic [SUM_W-1:0]           total_sum
);

    // Running prefix sums over the cores
    logic [SUM_W-1:0] prefix [NUM_CORES+1];

    assign prefix[0] = '0;

    genvar gi;
    generate
        for (gi = 0; gi < NUM_CORES; gi++) begin : g_acc
            assign prefix[gi+1] = prefix[gi]
                + {{(SUM_W-PWR_W){1'b0}}, core_pwr[gi*PWR_W +: PWR_W]};
        end
    endgenerate

    assign cpu_sum   = prefix[NUM_CORES];
    assign total_sum = prefix[NUM_CORES] + {{(SUM_W-PWR_W){1'b0}}, gpu_pwr};

endmodule

// File: rtl/pb_energy_bank.sv
module pb_energy_bank
    import pwr_budget_pkg::*;
#(
    parameter int unsigned SUM_W = pb_sum_w(PB_NUM_CORES, PB_PWR_W),
    parameter int unsigned ACC_W = PB_ACC_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [SUM_W-1:0] total_sum,
    input  logic [SUM_W-1:0] pkg_limit,
    input  logic [ACC_W-1:0] bank_max,
    input  logic [ACC_W-1:0] rearm_level,
    output logic             lock_d,
    output logic [ACC_W-1:0] margin_q,
    output logic             lock_q
);

    localparam int unsigned RAW_W = ACC_W + 2;

    logic signed [RAW_W-1:0] raw;
    logic signed [RAW_W-1:0] cap_s;
    logic        [ACC_W-1:0] margin_d;
    logic                    deficit;

    always_comb begin
        raw = $signed({2'b00, margin_q})
            + $signed({{(RAW_W-SUM_W){1'b0}}, pkg_limit})
            - $signed({{(RAW_W-SUM_W){1'b0}}, total_sum});
        cap_s   = $signed({2'b00, bank_max});
        deficit = raw < 0;
        if (deficit) begin
            margin_d = '0;
        end else if (raw > cap_s) begin
            margin_d = bank_max;
        end else begin
            margin_d = raw[ACC_W-1:0];
        end
        // Enter lockout on a deficit; leave only above the re-arm level
        if (deficit) begin
            lock_d = 1'b1;
        end else if (lock_q && (margin_d <= rearm_level)) begin
            lock_d = 1'b1;
        end else begin
            lock_d = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            margin_q <= '0;
            lock_q   <= 1'b0;
        end else begin
            margin_q <= margin_d;
            lock_q   <= lock_d;
        end
    end

    AST_MARGIN_CAPPED: assert property (@(posedge clk) disable iff (rst)
        margin_q <= $past(bank_max)); // R2

    AST_REARM_ABOVE_LEVEL: assert property (@(posedge clk) disable iff (rst)
        $fell(lock_q) |-> (margin_q > $past(rearm_level))); // R4

    AST_LOCK_MEANS_FLOOR: assert property (@(posedge clk) disable iff (rst)
        $rose(lock_q) |-> (margin_q == '0)); // R3

endmodule

// File: rtl/pb_credit_arb.sv
module pb_credit_arb
    import pwr_budget_pkg::*;
#(
    parameter int unsigned NUM_CORES = PB_NUM_CORES,
    parameter int unsigned PWR_W     = PB_PWR_W,
    parameter int unsigned SUM_W     = pb_sum_w(NUM_CORES, PWR_W)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [SUM_W-1:0]     cpu_sum,
    input  logic [PWR_W-1:0]     gpu_pwr,
    input  logic                 cpu_wants,
    input  logic                 gpu_borrow_req,
    input  logic [SUM_W-1:0]     cpu_dom_limit,
    input  logic [SUM_W-1:0]     gpu_dom_limit,
    input  logic [SUM_W-1:0]     borrow_quantum,
    input  logic [SUM_W-1:0]     idle_level,
    output logic [SUM_W:0]       cpu_eff_d,
    output logic                 gpu_credit_q,
    output logic                 cpu_credit_q,
    output logic [SUM_W:0]       cpu_eff_q,
    output logic [SUM_W:0]       gpu_eff_q
);

    logic          cpu_idle;
    logic          gpu_idle;
    credit_dir_e   dir;
    credit_flags_t flags;
    logic [SUM_W:0] gpu_eff_d;
    logic [SUM_W:0] quantum_x;

    assign cpu_idle  = cpu_sum <= idle_level;
    assign gpu_idle  = {{(SUM_W-PWR_W){1'b0}}, gpu_pwr} <= idle_level;
    assign quantum_x = {1'b0, borrow_quantum};

    // GPU is considered first; the CPU only takes an unclaimed quantum
    always_comb begin
        if (gpu_borrow_req && cpu_idle) begin
            dir = CR_TO_GPU;
        end else if (cpu_wants && gpu_idle) begin
            dir = CR_TO_CPU;
        end else begin
            dir = CR_NONE;
        end
        flags     = pb_decode_dir(dir);
        cpu_eff_d = {1'b0, cpu_dom_limit} + (flags.cpu ? quantum_x : '0);
        gpu_eff_d = {1'b0, gpu_dom_limit} + (flags.gpu ? quantum_x : '0);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            gpu_credit_q <= 1'b0;
            cpu_credit_q <= 1'b0;
            cpu_eff_q    <= '0;
            gpu_eff_q    <= '0;
        end else begin
            gpu_credit_q <= flags.gpu;
            cpu_credit_q <= flags.cpu;
            cpu_eff_q    <= cpu_eff_d;
            gpu_eff_q    <= gpu_eff_d;
        end
    end

    AST_ONE_BORROWER: assert property (@(posedge clk) disable iff (rst)
        !(gpu_credit_q && cpu_credit_q)); // R8

    AST_GPU_SERVED_FIRST: assert property (@(posedge clk) disable iff (rst)
        (gpu_borrow_req && cpu_idle) |=> (gpu_credit_q && !cpu_credit_q)); // R6

    AST_CPU_CREDIT_NEEDS_IDLE_GPU: assert property (@(posedge clk) disable iff (rst)
        cpu_credit_q |-> ($past(gpu_idle) && $past(cpu_wants))); // R7

endmodule

// File: rtl/pwr_budget_arbiter.sv
module pwr_budget_arbiter
    import pwr_budget_pkg::*;
#(
    parameter int unsigned NUM_CORES = PB_NUM_CORES,
    parameter int unsigned PWR_W     = PB_PWR_W,
    parameter int unsigned ACC_W     = PB_ACC_W,
    parameter int unsigned SUM_W     = pb_sum_w(NUM_CORES, PWR_W)
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic [NUM_CORES*PWR_W-1:0] core_pwr,
    input  logic [PWR_W-1:0]           gpu_pwr,
    input  logic [NUM_CORES-1:0]       core_boost_req,
    input  logic                       gpu_borrow_req,
    input  logic [SUM_W-1:0]           pkg_limit,
    input  logic [SUM_W-1:0]           cpu_dom_limit,
    input  logic [SUM_W-1:0]           gpu_dom_limit,
    input  logic [SUM_W-1:0]           borrow_quantum,
    input  logic [SUM_W-1:0]           idle_level,
    input  logic [ACC_W-1:0]           bank_max,
    input  logic [ACC_W-1:0]           rearm_level,
    output logic [NUM_CORES-1:0]       boost_gnt,
    output logic                       gpu_credit,
    output logic                       cpu_credit,
    output logic [SUM_W:0]             cpu_limit_eff,
    output logic [SUM_W:0]             gpu_limit_eff,
    output logic [ACC_W-1:0]           margin,
    output logic                       lockout
);

    logic [SUM_W-1:0] cpu_sum;
    logic [SUM_W-1:0] total_sum;
    logic             lock_d;
    logic [SUM_W:0]   cpu_eff_d;
    logic             cpu_fits;
    logic [NUM_CORES-1:0] boost_d;
    logic [NUM_CORES-1:0] boost_q;

    pb_power_sum #(
        .NUM_CORES (NUM_CORES),
        .PWR_W     (PWR_W),
        .SUM_W     (SUM_W)
    ) u_sum (
        .core_pwr  (core_pwr),
        .gpu_pwr   (gpu_pwr),
        .cpu_sum   (cpu_sum),
        .total_sum (total_sum)
    );

    pb_energy_bank #(
        .SUM_W (SUM_W),
        .ACC_W (ACC_W)
    ) u_bank (
        .clk         (clk),
        .rst         (rst),
        .total_sum   (total_sum),
        .pkg_limit   (pkg_limit),
        .bank_max    (bank_max),
        .rearm_level (rearm_level),
        .lock_d      (lock_d),
        .margin_q    (margin),
        .lock_q      (lockout)
    );

    pb_credit_arb #(
        .NUM_CORES (NUM_CORES),
        .PWR_W     (PWR_W),
        .SUM_W     (SUM_W)
    ) u_arb (
        .clk            (clk),
        .rst            (rst),
        .cpu_sum        (cpu_sum),
        .gpu_pwr        (gpu_pwr),
        .cpu_wants      (|core_boost_req),
        .gpu_borrow_req (gpu_borrow_req),
        .cpu_dom_limit  (cpu_dom_limit),
        .gpu_dom_limit  (gpu_dom_limit),
        .borrow_quantum (borrow_quantum),
        .idle_level     (idle_level),
        .cpu_eff_d      (cpu_eff_d),
        .gpu_credit_q   (gpu_credit),
        .cpu_credit_q   (cpu_credit),
        .cpu_eff_q      (cpu_limit_eff),
        .gpu_eff_q      (gpu_limit_eff)
    );

    assign cpu_fits = {1'b0, cpu_sum} <= cpu_eff_d;

    genvar ci;
    generate
        for (ci = 0; ci < NUM_CORES; ci++) begin : g_core
            assign boost_d[ci] = core_boost_req[ci] && !lock_d && cpu_fits;

            always_ff @(posedge clk) begin
                if (rst) begin
                    boost_q[ci] <= 1'b0;
                end else begin
                    boost_q[ci] <= boost_d[ci];
                end
            end

            AST_BOOST_NEEDS_REQ: assert property (@(posedge clk) disable iff (rst)
                boost_q[ci] |-> $past(core_boost_req[ci])); // R9
        end
    endgenerate

    assign boost_gnt = boost_q;

    AST_LOCK_FORCES_BASE: assert property (@(posedge clk) disable iff (rst)
        lockout |-> (boost_gnt == '0)); // R4

    AST_BOOST_WITHIN_DOMAIN: assert property (@(posedge clk) disable iff (rst)
        (|boost_gnt) |-> ({1'b0, $past(cpu_sum)} <= cpu_limit_eff)); // R10

endmodule

// File: tb/pwr_budget_arbiter_tb.sv
module pwr_budget_arbiter_tb;

    localparam int NC  = 4;
    localparam int PW  = 12;
    localparam int AW  = 20;
    localparam int SW  = 15;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [NC*PW-1:0]  core_pwr = '0;
    logic [PW-1:0]     gpu_pwr = '0;
    logic [NC-1:0]     core_boost_req = '0;
    logic              gpu_borrow_req = 1'b0;
    logic [SW-1:0]     pkg_limit = 15'd400;
    logic [SW-1:0]     cpu_dom_limit = 15'd450;
    logic [SW-1:0]     gpu_dom_limit = 15'd150;
    logic [SW-1:0]     borrow_quantum = 15'd60;
    logic [SW-1:0]     idle_level = 15'd20;
    logic [AW-1:0]     bank_max = 20'd1000;
    logic [AW-1:0]     rearm_level = 20'd150;
    logic [NC-1:0]     boost_gnt;
    logic              gpu_credit;
    logic              cpu_credit;
    logic [SW:0]       cpu_limit_eff;
    logic [SW:0]       gpu_limit_eff;
    logic [AW-1:0]     margin;
    logic              lockout;

    int n_checks = 0;
    int n_errors = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    pwr_budget_arbiter u_dut (
        .clk            (clk),
        .rst            (rst),
        .core_pwr       (core_pwr),
        .gpu_pwr        (gpu_pwr),
        .core_boost_req (core_boost_req),
        .gpu_borrow_req (gpu_borrow_req),
        .pkg_limit      (pkg_limit),
        .cpu_dom_limit  (cpu_dom_limit),
        .gpu_dom_limit  (gpu_dom_limit),
        .borrow_quantum (borrow_quantum),
        .idle_level     (idle_level),
        .bank_max       (bank_max),
        .rearm_level    (rearm_level),
        .boost_gnt      (boost_gnt),
        .gpu_credit     (gpu_credit),
        .cpu_credit     (cpu_credit),
        .cpu_limit_eff  (cpu_limit_eff),
        .gpu_limit_eff  (gpu_limit_eff),
        .margin         (margin),
        .lockout        (lockout)
    );

    task automatic check(input string req, input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic set_cores(input int v);
        for (int i = 0; i < NC; i++) core_pwr[i*PW +: PW] = v[PW-1:0];
    endtask

    task automatic t_reset();
        step();
        check("R11", "margin", int'(margin), 0);
        check("R11", "lockout", int'(lockout), 0);
        check("R11", "boost", int'(boost_gnt), 0);
        check("R11", "credits", int'({gpu_credit, cpu_credit}), 0);
        check("R11", "cpu_eff", int'(cpu_limit_eff), 0);
        rst = 1'b0;
    endtask

    task automatic t_accumulate();
        set_cores(50); gpu_pwr = 12'd100;          // total 300, +100 per edge
        for (int k = 1; k <= 3; k++) begin
            step();
            check("R1", "margin", int'(margin), 100 * k);
        end
    endtask

    task automatic t_cap();
        bank_max = 20'd350;                        // 300+100 clipped
        step();
        check("R2", "margin", int'(margin), 350);
    endtask

    task automatic t_overspend();
        set_cores(100); core_boost_req = 4'b1111;  // total 500, -100 per edge
        step();
        check("R5", "margin", int'(margin), 250);
        check("R5", "boost", int'(boost_gnt), 15);
        check("R5", "lockout", int'(lockout), 0);
    endtask

    task automatic t_deficit();
        step();
        check("R1", "margin", int'(margin), 150);
        step();
        check("R5", "boost before deficit", int'(boost_gnt), 15);
        step();                                     // 50-100 < 0
        check("R3", "margin floor", int'(margin), 0);
        check("R3", "lockout", int'(lockout), 1);
        check("R3", "boost", int'(boost_gnt), 0);
    endtask

    task automatic t_rearm();
        set_cores(60);                             // total 340, +60 per edge
        step();
        check("R4", "lock at 60", int'(lockout), 1);
        check("R4", "boost at 60", int'(boost_gnt), 0);
        step();
        check("R4", "lock at 120", int'(lockout), 1);
        step();
        check("R4", "margin", int'(margin), 180);
        check("R4", "lock released", int'(lockout), 0);
        check("R4", "boost resumes", int'(boost_gnt), 15);
    endtask

    task automatic t_independent();
        core_boost_req = 4'b0101;
        step();
        check("R9", "boost", int'(boost_gnt), 5);
    endtask

    task automatic t_domain_limit();
        cpu_dom_limit = 15'd200; core_boost_req = 4'b1111; // cpu 240 > 200
        step();
        check("R10", "boost", int'(boost_gnt), 0);
        check("R10", "cpu_credit", int'(cpu_credit), 0);
        check("R10", "cpu_eff", int'(cpu_limit_eff), 200);
    endtask

    task automatic t_cpu_borrow();
        gpu_pwr = 12'd10;                          // GPU idle
        step();
        check("R7", "cpu_credit", int'(cpu_credit), 1);
        check("R7", "gpu_credit", int'(gpu_credit), 0);
        check("R7", "cpu_eff", int'(cpu_limit_eff), 260);
        check("R7", "boost", int'(boost_gnt), 15);
        check("R2", "margin", int'(margin), 350);
    endtask

    task automatic t_gpu_borrow();
        set_cores(5); gpu_pwr = 12'd150; gpu_borrow_req = 1'b1; core_boost_req = '0;
        step();
        check("R6", "gpu_credit", int'(gpu_credit), 1);
        check("R6", "cpu_credit", int'(cpu_credit), 0);
        check("R6", "gpu_eff", int'(gpu_limit_eff), 210);
        check("R6", "boost", int'(boost_gnt), 0);
    endtask

    task automatic t_priority();
        gpu_pwr = 12'd10; core_boost_req = 4'b0001; // both domains idle, both ask
        step();
        check("R8", "gpu_credit", int'(gpu_credit), 1);
        check("R8", "cpu_credit", int'(cpu_credit), 0);
        check("R8", "cpu_eff", int'(cpu_limit_eff), 200);
        check("R9", "boost", int'(boost_gnt), 1);
    endtask

    initial begin
        t_reset();
        t_accumulate();
        t_cap();
        t_overspend();
        t_deficit();
        t_rearm();
        t_independent();
        t_domain_limit();
        t_cpu_borrow();
        t_gpu_borrow();
        t_priority();
        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: actual=timeout expected=done");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

endmodule